// File: doc/BRIEF.md
# Battery-Backed Byte Memory Pin Emulator

This block is a clocked model of a byte-wide static memory that keeps its contents when the supply fails. It watches three active-low strobes (chip select, write strobe, output gate), an address bus and a data-in bus. It holds the bytes in an internal array. It returns read data on a data-out bus, together with a drive-enable flag that a wrapper turns into a tri-state buffer. In a controller testbench it acts as the memory side. In an FPGA it can stand in for the real part.

A digital supply-good level replaces the analog supply monitor. While that level is low, the block drives nothing, ignores its pins and refuses every write. The array itself is never cleared, so its contents survive any number of supply drops. A write lands only when the select/strobe overlap closes, using the address and data sampled in the last cycle of the overlap. Every pin first passes through a synchronizer, so a pin change reaches the outputs after a fixed number of clocks.

Top module: `nvram_emu`

## Requirements
- R1: While reset is asserted and after it is released with all strobes high, `dout_oe` is 0.
- R2: When the supply is good, the write strobe is high, and chip select and output gate are both low, `dout_oe` is 1 and `dout` equals the byte stored at `addr`. Otherwise `dout_oe` is 0.
- R3: A write happens only while chip select and write strobe are both low. The byte is committed when the first of the two rises, with the address and data sampled in the last cycle of that overlap. This holds whether the write strobe or chip select ends the overlap, and a data change inside the overlap means the last value wins.
- R4: A low write strobe with chip select high does not alter the array. A low chip select with the write strobe high does not alter it either.
- R5: If a read is being driven and the write strobe falls, `dout_oe` returns to 0.
- R6: During a write with the output gate high, `dout_oe` stays 0.
- R7: While `pwr_ok` is 0, `dout_oe` is 0 and no strobe pattern changes the array.
- R8: A write whose overlap is interrupted by `pwr_ok` falling is discarded.
- R9: If the supply returns while chip select and write strobe are already both low, that overlap commits nothing. Writing needs a fresh overlap that begins with the supply good.
- R10: Array contents are unchanged across supply loss.
- R11: A pin change reaches `dout_oe` on the third rising clock edge after it is applied: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous active-low reset (does not clear the array) |
| ce_n | input | 1 | Chip select, active low |
| we_n | input | 1 | Write strobe, active low |
| oe_n | input | 1 | Output gate, active low |
| addr | input | ADDR_W | Byte address |
| din | input | DATA_W | Write data from the bus |
| pwr_ok | input | 1 | Supply within tolerance when 1 |
| dout | output | DATA_W | Read data |
| dout_oe | output | 1 | Drive enable for the data bus |

## Verification
The bench builds the block with a 4-bit address and 8-bit data, so the array has 16 bytes. This makes it practical to write and read back every location, more than once, with a pattern computed from the address. The small array puts every supply-drop scenario within reach: a write cut off by the drop, a supply return during a held overlap, and a full re-sweep after the supply recovers. Each scenario is checked against a bench-side model of the array. Two synchronizer stages fix the latency, so the exact edge at which the drive enable changes is also checked.

// File: rtl/nvram_pkg.sv
package nvram_pkg;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'd0,
        OP_READ  = 2'd1,
        OP_WRITE = 2'd2,
        OP_OFF   = 2'd3
    } nv_op_e;

endpackage

// File: rtl/nvram_sync.sv
module nvram_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg_q [STAGES];
    logic [W-1:0] stg_d [STAGES];

    always_comb begin
        stg_d[0] = d;
        for (int i = 1; i < STAGES; i++) begin
            stg_d[i] = stg_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= RST_VAL;
        end else begin
            for (int i = 0; i < STAGES; i++) stg_q[i] <= stg_d[i];
        end
    end

    assign q = stg_q[STAGES-1];
endmodule

// File: rtl/nvram_store.sv
module nvram_store #(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;

    // No reset: contents must outlive reset and supply loss.
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[wr_addr] <= wr_data;
    end

    assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/nvram_ctrl.sv
module nvram_ctrl
    import nvram_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_s,
    input  logic              we_s,
    input  logic              oe_s,
    input  logic              pwr_s,
    input  logic [ADDR_W-1:0] addr_s,
    input  logic [DATA_W-1:0] data_s,
    input  logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    typedef struct packed {
        logic              overlap;
        logic              armed;
        logic [ADDR_W-1:0] hold_addr;
        logic [DATA_W-1:0] hold_data;
        logic [DATA_W-1:0] dout;
        logic              dout_oe;
    } ctrl_st_t;

    ctrl_st_t st_d, st_q;
    nv_op_e   op;
    logic     overlap;
    logic     ov_start;
    logic     ov_end;

    always_comb begin
        overlap  = ~ce_s & ~we_s;
        ov_start = overlap & ~st_q.overlap;
        ov_end   = ~overlap & st_q.overlap;

        if (!pwr_s)                         op = OP_OFF;
        else if (overlap)                   op = OP_WRITE;
        else if (~ce_s & ~oe_s & we_s)      op = OP_READ;
        else                                op = OP_IDLE;

        st_d         = st_q;
        st_d.overlap = overlap;
        st_d.dout_oe = 1'b0;

        unique case (op)
            OP_OFF: begin
                st_d.armed = 1'b0;
            end
            OP_WRITE: begin
                if (ov_start) st_d.armed = 1'b1;
                st_d.hold_addr = addr_s;
                st_d.hold_data = data_s;
            end
            OP_READ: begin
                st_d.dout_oe = 1'b1;
                st_d.dout    = rd_data;
                if (ov_end) st_d.armed = 1'b0;
            end
            default: begin
                if (ov_end) st_d.armed = 1'b0;
            end
        endcase

        wr_en   = pwr_s & ov_end & st_q.armed;
        wr_addr = st_q.hold_addr;
        wr_data = st_q.hold_data;
        rd_addr = addr_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q         <= '0;
        end else begin
            st_q         <= st_d;
        end
    end

    assign dout    = st_q.dout;
    assign dout_oe = st_q.dout_oe;
endmodule

// File: rtl/nvram_emu.sv
module nvram_emu #(
    parameter int ADDR_W      = 13,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              we_n,
    input  logic              oe_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    input  logic              pwr_ok,
    output logic [DATA_W-1:0] dout,
    output logic              dout_oe
);
    localparam int BUS_W = ADDR_W + DATA_W;

    logic              ce_s, we_s, oe_s, pwr_s;
    logic [ADDR_W-1:0] addr_s;
    logic [DATA_W-1:0] data_s;
    logic [BUS_W-1:0]  bus_s;
    logic [DATA_W-1:0] rd_data;
    logic [ADDR_W-1:0] rd_addr;
    logic              wr_en;
    logic [ADDR_W-1:0] wr_addr;
    logic [DATA_W-1:0] wr_data;

    // Strobes idle high, supply assumed bad until proven good.
    nvram_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b1110)) u_sync_ctl (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ce_n, we_n, oe_n, pwr_ok}),
        .q     ({ce_s, we_s, oe_s, pwr_s})
    );

    // Bus delayed by the same depth so it stays aligned with the strobes.
    nvram_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({addr, din}),
        .q     (bus_s)
    );

    assign addr_s = bus_s[BUS_W-1:DATA_W];
    assign data_s = bus_s[DATA_W-1:0];

    nvram_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .ce_s    (ce_s),
        .we_s    (we_s),
        .oe_s    (oe_s),
        .pwr_s   (pwr_s),
        .addr_s  (addr_s),
        .data_s  (data_s),
        .rd_data (rd_data),
        .rd_addr (rd_addr),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .dout    (dout),
        .dout_oe (dout_oe)
    );

    nvram_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data)
    );
endmodule

// File: rtl/nvram_emu_chk.sv
module nvram_emu_chk (
    input logic clk,
    input logic rst_n,
    input logic ce_s,
    input logic we_s,
    input logic oe_s,
    input logic pwr_s,
    input logic wr_en,
    input logic dout_oe
);
    p_off_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |=> !dout_oe);

    p_off_nowrite_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !pwr_s |-> !wr_en);

    p_drive_needs_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr_s && !ce_s && !oe_s && we_s) |=> dout_oe);

    p_we_low_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !we_s |=> !dout_oe);

    p_oe_high_hiz_r6: assert property (@(posedge clk) disable iff (!rst_n)
        oe_s |=> !dout_oe);

    p_commit_at_end_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!(!ce_s && !we_s) && $past(!ce_s && !we_s)));
endmodule

bind nvram_emu nvram_emu_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .ce_s    (ce_s),
    .we_s    (we_s),
    .oe_s    (oe_s),
    .pwr_s   (pwr_s),
    .wr_en   (wr_en),
    .dout_oe (dout_oe)
);

// File: tb/nvram_emu_tb.sv
module nvram_emu_tb;
    localparam int AW = 4;
    localparam int DW = 8;
    localparam int N  = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1, pwr_ok = 1'b1;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic          dout_oe;

    int n_run = 0, n_fail = 0;
    bit done = 0;
    logic [DW-1:0] model [N];

    always #10 clk = ~clk;

    nvram_emu #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(2)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
        .addr(addr), .din(din), .pwr_ok(pwr_ok), .dout(dout), .dout_oe(dout_oe)
    );

    function automatic logic [DW-1:0] pat(input int a, input int salt);
        return DW'((a * 37 + 5 + salt * 11) & 255);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (6) @(negedge clk);
    endtask

    task automatic wr_we_end(input int a, input logic [DW-1:0] d);
        addr = AW'(a); din = d; ce_n = 0; we_n = 0; oe_n = 1; settle();
        we_n = 1; settle();
        ce_n = 1; settle();
        model[a] = d;
    endtask

    task automatic rd(input int a, output logic [DW-1:0] v, output logic oe);
        addr = AW'(a); ce_n = 0; oe_n = 0; we_n = 1; settle();
        v = dout; oe = dout_oe;
        ce_n = 1; oe_n = 1; settle();
    endtask

    task automatic rd_chk(input int a, input string req);
        logic [DW-1:0] v; logic oe;
        rd(a, v, oe);
        chk(oe === 1'b1, req, oe, 1);
        chk(v === model[a], req, v, model[a]);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v; logic oe;
        repeat (3) @(negedge clk);
        chk(dout_oe === 1'b0, "R1 in reset", dout_oe, 0);
        rst_n = 1; settle();
        chk(dout_oe === 1'b0, "R1 after reset", dout_oe, 0);

        // R3/R2: full sweep, write-strobe ends overlap
        for (int a = 0; a < N; a++) wr_we_end(a, pat(a, 0));
        for (int a = 0; a < N; a++) rd_chk(a, "R2 sweep read");

        // R3: chip select ends overlap, data changes mid-overlap
        addr = 4'd5; din = 8'h11; we_n = 0; settle();
        ce_n = 0; settle();
        din = 8'hA7; settle();
        ce_n = 1; settle();
        we_n = 1; settle();
        model[5] = 8'hA7;
        rd_chk(5, "R3 ce-ended last data");

        // R4: strobe low alone does nothing
        addr = 4'd6; din = ~model[6]; we_n = 0; ce_n = 1; settle();
        we_n = 1; settle();
        ce_n = 0; settle(); ce_n = 1; settle();
        rd_chk(6, "R4 lone strobe");

        // R5: write strobe falling during read disables drive
        addr = 4'd7; ce_n = 0; oe_n = 0; we_n = 1; settle();
        chk(dout_oe === 1'b1, "R5 pre read", dout_oe, 1);
        din = 8'h3C; we_n = 0; settle();
        chk(dout_oe === 1'b0, "R5 we low", dout_oe, 0);
        we_n = 1; oe_n = 1; ce_n = 1; settle();
        model[7] = 8'h3C;

        // R6: output gate high during write
        addr = 4'd8; din = 8'h5A; ce_n = 0; we_n = 0; oe_n = 1; settle();
        chk(dout_oe === 1'b0, "R6 write oe high", dout_oe, 0);
        we_n = 1; ce_n = 1; settle();
        model[8] = 8'h5A;
        rd_chk(8, "R6 write landed");

        // R7: supply bad
        pwr_ok = 0; settle();
        addr = 4'd3; ce_n = 0; oe_n = 0; we_n = 1; settle();
        chk(dout_oe === 1'b0, "R7 off read hiz", dout_oe, 0);
        din = ~model[3]; we_n = 0; oe_n = 1; settle();
        we_n = 1; ce_n = 1; settle();
        pwr_ok = 1; settle();
        rd_chk(3, "R7 off write ignored");

        // R8: overlap cut by supply drop
        addr = 4'd9; din = ~model[9]; ce_n = 0; we_n = 0; settle();
        pwr_ok = 0; settle();
        we_n = 1; ce_n = 1; settle();
        pwr_ok = 1; settle();
        rd_chk(9, "R8 cut write discarded");

        // R9: supply returns during held overlap
        pwr_ok = 0; settle();
        addr = 4'd10; din = ~model[10]; ce_n = 0; we_n = 0; settle();
        pwr_ok = 1; settle();
        we_n = 1; ce_n = 1; settle();
        rd_chk(10, "R9 no commit on return");
        wr_we_end(10, 8'hC3);
        rd_chk(10, "R9 fresh overlap");

        // R10: persistence across supply loss
        pwr_ok = 0; repeat (40) @(negedge clk);
        pwr_ok = 1; settle();
        for (int a = 0; a < N; a++) rd_chk(a, "R10 persist");

        // R11: latency of drive enable
        addr = 4'd2; ce_n = 0; oe_n = 0; we_n = 1;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk(dout_oe === 1'b0, "R11 two edges", dout_oe, 0);
        @(negedge clk);
        chk(dout_oe === 1'b1, "R11 third edge", dout_oe, 1);
        chk(dout === model[2], "R11 data", dout, model[2]);
        ce_n = 1; oe_n = 1; settle();

        // second sweep with new pattern, read via R2
        for (int a = 0; a < N; a++) wr_we_end(a, pat(a, 3));
        for (int a = 0; a < N; a++) rd_chk(a, "R2 sweep2");
        rd(0, v, oe);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule